// File: doc/BRIEF.md
# Sideload Key Slot Manager

This block holds generated keys for three hardware consumers: a cipher engine, a MAC engine and a big-number coprocessor. Each consumer has one slot. A slot keeps a key as two shares, shows a valid bit, and tracks its own availability status. Key-load strobes carry a destination code and two shares. A write strobe carries a clear-select value from a software-written register. A global wipe input models a fatal error or a disable from the lifecycle. Key derivation, the register bus and entropy sourcing sit outside this block.

A slot that has been cleared cannot take a new key right away. It first has to be released by a later write of the clear-select register. Clearing overwrites the stored shares with a pattern taken from a free-running LFSR. Share 1 is always the bitwise complement of share 0, so the two shares never combine into a real key.

The MAC slot is shared with the internal derivation path. While a derivation runs, the MAC outputs carry the internal working key. When the derivation ends, the outputs go back to the stored MAC key, or drop valid if no key is available.

Top module: `sideload_slots`

## Requirements
- R1: After reset, every slot status reads NotAvail (code 0), every valid output is 0 and every share output is 0.
- R2: A load strobe sets a slot to Avail (code 1) and raises its valid from the next cycle, showing the loaded shares, if all of these hold in that cycle: the slot is not in Clear (code 2), there is no clear write and there is no global wipe. Destination codes are 0 cipher, 1 MAC, 2 coprocessor. Code 3 changes nothing.
- R3: The coprocessor slot stores the full WIDE_W bits of each share. The cipher and MAC slots store only the low KEY_W bits.
- R4: A slot in Clear ignores loads and stays in Clear until a clear write or a global wipe happens.
- R5: The clear-select codes are: 0 idle, 1 cipher, 2 MAC, 3 coprocessor, and 4 to 7 all three slots. A write clears each selected slot: its status becomes Clear (code 2) and its valid drops.
- R6: Every clear write first returns each slot that is in Clear to NotAvail, and then applies its own selection. A write of idle therefore only releases slots.
- R7: A cleared or wiped slot shows share 1 as the bitwise complement of share 0. The pattern comes from a free-running LFSR, so wipes made in different cycles give different patterns.
- R8: From the cycle after the derivation-busy input is sampled high without done, and until the cycle after done, the MAC outputs carry the internal key with valid 1.
- R9: After the derivation ends, the MAC outputs show the stored MAC slot. Its valid is 1 only if that slot is Avail.
- R10: A global wipe puts all three slots into Clear, drops every valid and ends any MAC override.
- R11: Priority within one cycle: the global wipe wins over a clear write, a clear write blocks every load in that cycle, and a clear that selects the MAC slot also ends the MAC override.
- R12: The key and valid outputs show a clear or wipe in the first cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Key load strobe |
| load_dst_i | input | 2 | Load destination (0 cipher, 1 MAC, 2 coprocessor) |
| load_s0_i | input | WIDE_W | Loaded share 0 |
| load_s1_i | input | WIDE_W | Loaded share 1 |
| kdf_busy_i | input | 1 | Internal derivation running |
| kdf_done_i | input | 1 | Internal derivation finished (pulse) |
| kdf_s0_i | input | KEY_W | Internal working key share 0 |
| kdf_s1_i | input | KEY_W | Internal working key share 1 |
| clr_we_i | input | 1 | Clear-select register write strobe |
| clr_data_i | input | 3 | Clear-select value written |
| wipe_i | input | 1 | Global wipe request |
| ciph_st_o | output | 2 | Cipher slot status (0 NotAvail, 1 Avail, 2 Clear) |
| ciph_vld_o | output | 1 | Cipher key valid |
| ciph_s0_o | output | KEY_W | Cipher key share 0 |
| ciph_s1_o | output | KEY_W | Cipher key share 1 |
| mac_st_o | output | 2 | MAC slot status |
| mac_vld_o | output | 1 | MAC key valid |
| mac_s0_o | output | KEY_W | MAC key share 0 |
| mac_s1_o | output | KEY_W | MAC key share 1 |
| cop_st_o | output | 2 | Coprocessor slot status |
| cop_vld_o | output | 1 | Coprocessor key valid |
| cop_s0_o | output | WIDE_W | Coprocessor key share 0 |
| cop_s1_o | output | WIDE_W | Coprocessor key share 1 |

## Verification
A wrong slot status shows up in two ways. It appears at once on the status and valid ports. A slot stuck in Clear also keeps ignoring loads, so a load in the next cycle does not show its key. A stale override flag keeps the internal key on the MAC outputs one cycle past done, or drops it one cycle early. The reference model compares these outputs on every clock, so such a fault is caught in the cycle it becomes visible. A missing wipe leaves the old shares readable instead of a complementary pair, and that is also caught in the first cycle after the clear.

// File: rtl/sideload_slots.sv
module sideload_slots #(
  parameter int KEY_W = 256,
  parameter int WIDE_W = 384,
  parameter int LFSR_W = 32,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h1D3A_5C71,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        load_dst_i,
  input  logic [WIDE_W-1:0] load_s0_i,
  input  logic [WIDE_W-1:0] load_s1_i,
  input  logic              kdf_busy_i,
  input  logic              kdf_done_i,
  input  logic [KEY_W-1:0]  kdf_s0_i,
  input  logic [KEY_W-1:0]  kdf_s1_i,
  input  logic              clr_we_i,
  input  logic [2:0]        clr_data_i,
  input  logic              wipe_i,
  output logic [1:0]        ciph_st_o,
  output logic              ciph_vld_o,
  output logic [KEY_W-1:0]  ciph_s0_o,
  output logic [KEY_W-1:0]  ciph_s1_o,
  output logic [1:0]        mac_st_o,
  output logic              mac_vld_o,
  output logic [KEY_W-1:0]  mac_s0_o,
  output logic [KEY_W-1:0]  mac_s1_o,
  output logic [1:0]        cop_st_o,
  output logic              cop_vld_o,
  output logic [WIDE_W-1:0] cop_s0_o,
  output logic [WIDE_W-1:0] cop_s1_o
);
  localparam int NSLOT = 3;
  localparam int SL_CIPH = 0;
  localparam int SL_MAC = 1;
  localparam int SL_COP = 2;
  localparam logic [1:0] ST_NONE = 2'd0;
  localparam logic [1:0] ST_AVAIL = 2'd1;
  localparam logic [1:0] ST_CLR = 2'd2;

  logic [LFSR_W-1:0] lfsr_q;
  logic [WIDE_W-1:0] wipe_pat;
  logic [NSLOT-1:0]  sel_hit, clr_hit, kill, ld_hit;
  logic [1:0]        st_q [NSLOT];
  logic [KEY_W-1:0]  ciph_s0_q, ciph_s1_q, mac_s0_q, mac_s1_q;
  logic [WIDE_W-1:0] cop_s0_q, cop_s1_q;
  logic              ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= LFSR_SEED;
    else lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
  end

  always_comb begin
    for (int b = 0; b < WIDE_W; b++) wipe_pat[b] = lfsr_q[b % LFSR_W];
  end

  always_comb begin
    case (clr_data_i)
      3'd0: sel_hit = 3'b000;
      3'd1: sel_hit = 3'b001;
      3'd2: sel_hit = 3'b010;
      3'd3: sel_hit = 3'b100;
      default: sel_hit = 3'b111;
    endcase
  end

  assign clr_hit = clr_we_i ? sel_hit : '0;
  assign kill = wipe_i ? '1 : clr_hit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign ld_hit[i] = load_i && !wipe_i && !clr_we_i && (load_dst_i == 2'(i))
                       && (st_q[i] != ST_CLR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= ST_NONE;
      else if (kill[i]) st_q[i] <= ST_CLR;
      else if (clr_we_i && st_q[i] == ST_CLR) st_q[i] <= ST_NONE;
      else if (ld_hit[i]) st_q[i] <= ST_AVAIL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ciph_s0_q <= '0;
      ciph_s1_q <= '0;
    end else if (kill[SL_CIPH]) begin
      ciph_s0_q <= wipe_pat[KEY_W-1:0];
      ciph_s1_q <= ~wipe_pat[KEY_W-1:0];
    end else if (ld_hit[SL_CIPH]) begin
      ciph_s0_q <= load_s0_i[KEY_W-1:0];
      ciph_s1_q <= load_s1_i[KEY_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mac_s0_q <= '0;
      mac_s1_q <= '0;
    end else if (kill[SL_MAC]) begin
      mac_s0_q <= wipe_pat[KEY_W-1:0];
      mac_s1_q <= ~wipe_pat[KEY_W-1:0];
    end else if (ld_hit[SL_MAC]) begin
      mac_s0_q <= load_s0_i[KEY_W-1:0];
      mac_s1_q <= load_s1_i[KEY_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cop_s0_q <= '0;
      cop_s1_q <= '0;
    end else if (kill[SL_COP]) begin
      cop_s0_q <= wipe_pat;
      cop_s1_q <= ~wipe_pat;
    end else if (ld_hit[SL_COP]) begin
      cop_s0_q <= load_s0_i;
      cop_s1_q <= load_s1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else if (kill[SL_MAC] || kdf_done_i) ovr_q <= 1'b0;
    else if (kdf_busy_i) ovr_q <= 1'b1;
  end

  assign ciph_st_o  = st_q[SL_CIPH];
  assign ciph_vld_o = st_q[SL_CIPH] == ST_AVAIL;
  assign ciph_s0_o  = ciph_s0_q;
  assign ciph_s1_o  = ciph_s1_q;

  assign mac_st_o  = st_q[SL_MAC];
  assign mac_vld_o = ovr_q || st_q[SL_MAC] == ST_AVAIL;
  assign mac_s0_o  = ovr_q ? kdf_s0_i : mac_s0_q;
  assign mac_s1_o  = ovr_q ? kdf_s1_i : mac_s1_q;

  assign cop_st_o  = st_q[SL_COP];
  assign cop_vld_o = st_q[SL_COP] == ST_AVAIL;
  assign cop_s0_o  = cop_s0_q;
  assign cop_s1_o  = cop_s1_q;
endmodule

module sideload_slots_chk #(
  parameter int WIDE_W = 384
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [1:0]        load_dst_i,
  input logic              kdf_busy_i,
  input logic              kdf_done_i,
  input logic              clr_we_i,
  input logic [2:0]        clr_data_i,
  input logic              wipe_i,
  input logic [1:0]        ciph_st_o,
  input logic              ciph_vld_o,
  input logic [1:0]        mac_st_o,
  input logic              mac_vld_o,
  input logic [1:0]        cop_st_o,
  input logic              cop_vld_o,
  input logic [WIDE_W-1:0] cop_s0_o,
  input logic [WIDE_W-1:0] cop_s1_o
);
  // R2
  ciph_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && load_dst_i == 2'd0 && !wipe_i && !clr_we_i && ciph_st_o != 2'd2
    |=> ciph_st_o == 2'd1 && ciph_vld_o);
  // R4
  clear_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ciph_st_o == 2'd2 && !clr_we_i |=> ciph_st_o == 2'd2);
  // R5
  ciph_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_data_i == 3'd1 |=> ciph_st_o == 2'd2 && !ciph_vld_o);
  // R7
  wipe_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_st_o == 2'd2 |-> cop_s1_o == ~cop_s0_o);
  // R8
  mac_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kdf_busy_i && !kdf_done_i && !wipe_i
    && !(clr_we_i && (clr_data_i == 3'd2 || clr_data_i[2])) |=> mac_vld_o);
  // R9
  mac_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kdf_done_i && !wipe_i && !clr_we_i && !load_i && mac_st_o != 2'd1 |=> !mac_vld_o);
  // R10
  wipe_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> ciph_st_o == 2'd2 && mac_st_o == 2'd2 && cop_st_o == 2'd2
    && !ciph_vld_o && !mac_vld_o && !cop_vld_o);
endmodule

bind sideload_slots sideload_slots_chk #(.WIDE_W(WIDE_W)) i_slots_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_dst_i(load_dst_i),
  .kdf_busy_i(kdf_busy_i), .kdf_done_i(kdf_done_i), .clr_we_i(clr_we_i),
  .clr_data_i(clr_data_i), .wipe_i(wipe_i), .ciph_st_o(ciph_st_o),
  .ciph_vld_o(ciph_vld_o), .mac_st_o(mac_st_o), .mac_vld_o(mac_vld_o),
  .cop_st_o(cop_st_o), .cop_vld_o(cop_vld_o), .cop_s0_o(cop_s0_o), .cop_s1_o(cop_s1_o));

// File: tb/test_sideload_slots.sv
module test_sideload_slots;
  localparam int KEY_W = 256;
  localparam int WIDE_W = 384;
  localparam logic [WIDE_W-1:0] NMASK = {{(WIDE_W-KEY_W){1'b0}}, {KEY_W{1'b1}}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0; logic [1:0] dst = 0;
  logic [WIDE_W-1:0] ls0 = '0, ls1 = '0;
  logic busy = 0, done = 0;
  logic [KEY_W-1:0] ks0 = '0, ks1 = '0;
  logic cwe = 0; logic [2:0] cdat = 0; logic wipe = 0;
  logic [1:0] c_st, m_st_o, p_st;
  logic c_v, m_v, p_v;
  logic [KEY_W-1:0] c0, c1, mk0, mk1;
  logic [WIDE_W-1:0] p0, p1;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  sideload_slots i_sideload_slots (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_dst_i(dst), .load_s0_i(ls0),
    .load_s1_i(ls1), .kdf_busy_i(busy), .kdf_done_i(done), .kdf_s0_i(ks0), .kdf_s1_i(ks1),
    .clr_we_i(cwe), .clr_data_i(cdat), .wipe_i(wipe),
    .ciph_st_o(c_st), .ciph_vld_o(c_v), .ciph_s0_o(c0), .ciph_s1_o(c1),
    .mac_st_o(m_st_o), .mac_vld_o(m_v), .mac_s0_o(mk0), .mac_s1_o(mk1),
    .cop_st_o(p_st), .cop_vld_o(p_v), .cop_s0_o(p0), .cop_s1_o(p1));

  // reference model
  int m_st [3];
  logic [WIDE_W-1:0] m_k0 [3], m_k1 [3];
  bit m_wiped [3];
  bit m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_k0[i] = '0; m_k1[i] = '0; m_wiped[i] = 0; end
      m_ovr = 0;
    end else if (wipe) begin
      for (int i = 0; i < 3; i++) begin m_st[i] = 2; m_wiped[i] = 1; end
      m_ovr = 0;
    end else if (cwe) begin
      bit hit [3];
      for (int i = 0; i < 3; i++) hit[i] = (cdat >= 4) || (int'(cdat) == i + 1);
      for (int i = 0; i < 3; i++) begin
        if (hit[i]) begin m_st[i] = 2; m_wiped[i] = 1; end
        else if (m_st[i] == 2) m_st[i] = 0;
      end
      if (hit[1] || done) m_ovr = 0; else if (busy) m_ovr = 1;
    end else begin
      if (load && dst != 2'd3 && m_st[dst] != 2) begin
        m_st[dst] = 1; m_wiped[dst] = 0;
        m_k0[dst] = (dst == 2'd2) ? ls0 : (ls0 & NMASK);
        m_k1[dst] = (dst == 2'd2) ? ls1 : (ls1 & NMASK);
      end
      if (done) m_ovr = 0; else if (busy) m_ovr = 1;
    end
  end

  task automatic chk(bit ok, string tag, logic [WIDE_W-1:0] act, logic [WIDE_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WIDE_W-1:0] rnd_wide();
    logic [WIDE_W-1:0] r;
    for (int w = 0; w < WIDE_W / 32; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic int act_st(int i);
    return i == 0 ? int'(c_st) : i == 1 ? int'(m_st_o) : int'(p_st);
  endfunction
  function automatic bit act_v(int i);
    return i == 0 ? c_v : i == 1 ? m_v : p_v;
  endfunction
  function automatic logic [WIDE_W-1:0] act_s0(int i);
    return i == 0 ? WIDE_W'(c0) : i == 1 ? WIDE_W'(mk0) : p0;
  endfunction
  function automatic logic [WIDE_W-1:0] act_s1(int i);
    return i == 0 ? WIDE_W'(c1) : i == 1 ? WIDE_W'(mk1) : p1;
  endfunction

  // R2/R5/R6/R8/R9 model comparison on every cycle
  task automatic compare();
    for (int i = 0; i < 3; i++) begin
      logic [WIDE_W-1:0] msk = (i == 2) ? '1 : NMASK;
      bit ev = (i == 1 && m_ovr) ? 1'b1 : (m_st[i] == 1);
      chk(act_st(i) == m_st[i], "R2/R5/R6 status", WIDE_W'(act_st(i)), WIDE_W'(m_st[i]));
      chk(act_v(i) == ev, "R2/R8/R9 valid", WIDE_W'(act_v(i)), WIDE_W'(ev));
      if (i == 1 && m_ovr)
        chk(act_s0(i) == WIDE_W'(ks0) && act_s1(i) == WIDE_W'(ks1), "R8 internal key",
            act_s0(i), WIDE_W'(ks0));
      else if (m_wiped[i])
        chk((act_s0(i) ^ act_s1(i)) == msk, "R7 wiped shares", act_s0(i) ^ act_s1(i), msk);
      else
        chk(act_s0(i) == m_k0[i] && act_s1(i) == m_k1[i], "R3 stored shares",
            act_s0(i), m_k0[i]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    load = 0; cwe = 0; wipe = 0; done = 0;
  endtask

  task automatic do_load(logic [1:0] d, logic [WIDE_W-1:0] a, logic [WIDE_W-1:0] b);
    load = 1; dst = d; ls0 = a; ls1 = b; step();
  endtask

  task automatic do_clr(logic [2:0] v);
    cwe = 1; cdat = v; step();
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WIDE_W-1:0] ka, kb, kc, pat1, pat2;
    ka = rnd_wide(); kb = rnd_wide(); kc = rnd_wide();
    ks0 = rnd_wide()[KEY_W-1:0]; ks1 = rnd_wide()[KEY_W-1:0];
    repeat (3) @(negedge clk);
    // R1
    chk(c_st == 0 && m_st_o == 0 && p_st == 0, "R1 reset status", WIDE_W'({c_st, m_st_o, p_st}), '0);
    chk(!c_v && !m_v && !p_v && p0 == '0 && c1 == '0, "R1 reset valids/shares", WIDE_W'({c_v, m_v, p_v}), '0);
    rst_n = 1;
    step();
    // R2, R3
    do_load(2'd0, ka, ~ka);
    chk(c_v && c0 == ka[KEY_W-1:0], "R2 cipher load", WIDE_W'(c0), ka & NMASK);
    do_load(2'd1, kb, ~kb);
    do_load(2'd2, kc, ~kc);
    chk(p0 == kc && p1 == ~kc, "R3 coprocessor full width", p0, kc);
    do_load(2'd3, ka, ka);
    chk(c0 == ka[KEY_W-1:0], "R2 destination 3 ignored", WIDE_W'(c0), ka & NMASK);
    // R5, R12, R7
    do_clr(3'd1);
    chk(c_st == 2 && !c_v, "R12 clear seen next cycle", WIDE_W'({c_st, c_v}), WIDE_W'(4));
    pat1 = WIDE_W'(c0);
    chk(c1 == ~c0, "R7 complement", WIDE_W'(c1), WIDE_W'(~c0));
    // R4
    do_load(2'd0, kb, kb);
    step();
    chk(c_st == 2 && !c_v && c0 == pat1[KEY_W-1:0], "R4 load into Clear ignored", WIDE_W'(c0), pat1);
    // R6
    do_clr(3'd0);
    chk(c_st == 0 && m_st_o == 1, "R6 idle write releases", WIDE_W'({c_st, m_st_o}), WIDE_W'(1));
    do_load(2'd0, kb, ~kb);
    repeat (5) step();
    do_clr(3'd1);
    pat2 = WIDE_W'(c0);
    chk(pat2 != pat1, "R7 pattern changes between wipes", pat2, pat1);
    do_clr(3'd2);
    chk(c_st == 0 && m_st_o == 2, "R6 release then select", WIDE_W'({c_st, m_st_o}), WIDE_W'(2));
    do_clr(3'd0);
    // R8, R9
    do_load(2'd1, ka, ~ka);
    busy = 1; step();
    chk(m_v && mk0 == ks0, "R8 override shows internal key", WIDE_W'(mk0), WIDE_W'(ks0));
    repeat (3) step();
    done = 1; busy = 0; step();
    chk(m_v && mk0 == ka[KEY_W-1:0], "R9 back to stored key", WIDE_W'(mk0), ka & NMASK);
    do_clr(3'd2); do_clr(3'd0);
    busy = 1; step(); busy = 0; done = 1; step();
    chk(!m_v, "R9 valid drops without stored key", WIDE_W'(m_v), '0);
    // R5 all
    do_load(2'd0, ka, kb); do_load(2'd2, kb, kc);
    do_clr(3'd6);
    chk(c_st == 2 && m_st_o == 2 && p_st == 2, "R5 clear all", WIDE_W'({c_st, m_st_o, p_st}), WIDE_W'(6'h2a));
    do_clr(3'd0);
    // R10, R11
    do_load(2'd1, kc, ka);
    busy = 1; step();
    wipe = 1; load = 1; dst = 2'd0; cwe = 1; cdat = 3'd0; step();
    busy = 0;
    chk(!c_v && !m_v && !p_v && c_st == 2, "R10 global wipe", WIDE_W'({c_v, m_v, p_v}), '0);
    do_clr(3'd0);
    load = 1; dst = 2'd2; ls0 = ka; cwe = 1; cdat = 3'd1; step();
    chk(p_st == 0 && !p_v, "R11 clear write blocks load", WIDE_W'(p_st), '0);
    do_clr(3'd0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      load = ($urandom % 3) == 0; dst = 2'($urandom); ls0 = rnd_wide(); ls1 = rnd_wide();
      busy = ($urandom % 4) == 0; done = ($urandom % 6) == 0;
      ks0 = rnd_wide()[KEY_W-1:0]; ks1 = rnd_wide()[KEY_W-1:0];
      cwe = ($urandom % 8) == 0; cdat = 3'($urandom); wipe = ($urandom % 50) == 0;
      step();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule